// File: doc/BRIEF.md
# Precise-Interrupt Pipeline Tracker

This block follows instructions through a five-stage in-order pipeline: fetch, decode, operand fetch, execute and write-back. Each stage keeps one valid flag and the address of the instruction it holds. All stages shift forward together on each unstalled clock. The fetch side is a counter that yields the next sequential address. Decoding, register access, arithmetic and forwarding belong to other blocks. This block only records which address sits in which stage and when it leaves.

An accepted interrupt makes the interrupt precise. The instruction in write-back finishes in that cycle and every younger stage is emptied. Fetch jumps to a fixed handler address, and the address at which the program must resume is kept in a saved-address register. While the handler runs, further requests are masked. A return pulse sends fetch back to the saved address and clears the handler flag.

Top module: `pipe_irq_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, all five stage valid flags clear, `in_handler_o` clears and `fetch_addr_o` becomes 0 after that edge.
- R2: In a cycle with no stall, no accepted interrupt and no accepted return, the fetch stage captures `fetch_addr_o` with valid set, and each stage passes its content to the next. `fetch_addr_o` then rises by one. `stage_valid_o` bit 0 is fetch and bit 4 is write-back.
- R3: `retire_o` is high, with `retire_addr_o` equal to the write-back address, exactly in cycles where write-back is valid and either no stall is asserted or an interrupt or return is accepted. Without redirects, addresses retire in fetch order five unstalled cycles after fetch.
- R4: With `stall_i` high and no interrupt or return accepted, the stage contents and `fetch_addr_o` stay unchanged and `retire_o` stays low.
- R5: An interrupt is accepted when `irq_i` is high and `in_handler_o` is low. After that edge all stage valid flags are 0, `fetch_addr_o` equals `HANDLER_BASE` and `in_handler_o` is 1.
- R6: On acceptance `saved_addr_o` is loaded with the resume address, and it changes at no other time. The resume address is the write-back address plus one when write-back is valid. Otherwise it is the address of the oldest valid younger stage (execute first, fetch last). If all stages are empty it is the current fetch address.
- R7: While `in_handler_o` is high, `irq_i` has no effect.
- R8: A return is accepted when `rfi_i` is high and `in_handler_o` is high. It retires a valid write-back instruction and empties every stage. On the next edge `fetch_addr_o` takes the saved address and `in_handler_o` clears. When `in_handler_o` is low, `rfi_i` is ignored.
- R9: An interrupt is accepted during a stall, and the valid write-back instruction still retires in that cycle.
- R10: No address that was squashed by an interrupt or a return ever appears on `retire_addr_o` with `retire_o` high.
- R11: When `irq_i` and `rfi_i` are both high while in the handler, the return is taken and the interrupt is ignored in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stall_i | input | 1 | Freeze the pipeline and the fetch counter |
| irq_i | input | 1 | Interrupt request level |
| rfi_i | input | 1 | Return-from-handler pulse |
| fetch_addr_o | output | ADDR_W | Address the fetch stage captures next |
| stage_valid_o | output | 5 | Valid flags, bit 0 fetch to bit 4 write-back |
| retire_o | output | 1 | An instruction leaves write-back this cycle |
| retire_addr_o | output | ADDR_W | Address of the retiring instruction |
| in_handler_o | output | 1 | Handler running, interrupts masked |
| saved_addr_o | output | ADDR_W | Resume address captured on interrupt |

## Verification
Two functions can fall in the same cycle: a stall and an accepted interrupt, and a handler return together with a fresh interrupt request. The bench raises `stall_i` and `irq_i` in one cycle while write-back holds a valid instruction. It expects that instruction to retire, the younger stages to empty and fetch to go to the handler. It also raises `rfi_i` and `irq_i` together inside the handler and expects the return to win, with `in_handler_o` low. A reference model and a scoreboard queue of expected retire addresses judge each cycle, so a squashed address that retires, or a retire that is missing, is reported.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int PIC_STAGES = 5;
  localparam int ST_IF = 0;
  localparam int ST_EX = 3;
  localparam int ST_WB = 4;

  // what the fetch counter does at the next edge
  typedef enum logic [1:0] {
    FSEL_HOLD    = 2'd0,
    FSEL_SEQ     = 2'd1,
    FSEL_HANDLER = 2'd2,
    FSEL_RESUME  = 2'd3
  } pic_fsel_e;
endpackage

// File: rtl/pic_fetch_pc.sv
module pic_fetch_pc
  import pic_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] HANDLER_BASE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  pic_fsel_e         sel,
  input  logic [ADDR_W-1:0] resume_addr,
  output logic [ADDR_W-1:0] pc_o
);
  function automatic logic [ADDR_W-1:0] seq_next(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_o <= '0;
    end else begin
      unique case (sel)
        FSEL_SEQ:     pc_o <= seq_next(pc_o);
        FSEL_HANDLER: pc_o <= HANDLER_BASE;
        FSEL_RESUME:  pc_o <= resume_addr;
        default:      pc_o <= pc_o;
      endcase
    end
  end
endmodule

// File: rtl/pic_stage_chain.sv
module pic_stage_chain
  import pic_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         advance,
  input  logic                         squash,
  input  logic [ADDR_W-1:0]            in_addr,
  output logic [PIC_STAGES-1:0]        valid_o,
  output logic [PIC_STAGES*ADDR_W-1:0] addr_o
);
  logic [PIC_STAGES-1:0]   v_q;
  logic [ADDR_W-1:0]       a_q [PIC_STAGES];

  for (genvar s = 0; s < PIC_STAGES; s++) begin : g_stage
    logic              src_v;
    logic [ADDR_W-1:0] src_a;
    if (s == ST_IF) begin : g_head
      assign src_v = 1'b1;
      assign src_a = in_addr;
    end else begin : g_body
      assign src_v = v_q[s-1];
      assign src_a = a_q[s-1];
    end

    always_ff @(posedge clk) begin
      if (rst || squash) begin
        v_q[s] <= 1'b0;
      end else if (advance) begin
        v_q[s] <= src_v;
        a_q[s] <= src_a;
      end
    end

    assign addr_o[s*ADDR_W +: ADDR_W] = a_q[s];
  end

  assign valid_o = v_q;
endmodule

// File: rtl/pic_resume_pick.sv
module pic_resume_pick
  import pic_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [PIC_STAGES-1:0]        valid_i,
  input  logic [PIC_STAGES*ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0]            pc_i,
  output logic [ADDR_W-1:0]            resume_o
);
  // write-back valid: next in sequence; else oldest squashed; else fetch pc
  function automatic logic [ADDR_W-1:0] pick(
    input logic [PIC_STAGES-1:0]        v,
    input logic [PIC_STAGES*ADDR_W-1:0] a,
    input logic [ADDR_W-1:0]            pc
  );
    logic [ADDR_W-1:0] r;
    r = pc;
    for (int s = ST_IF; s <= ST_EX; s++) begin
      if (v[s]) r = a[s*ADDR_W +: ADDR_W];
    end
    if (v[ST_WB]) r = a[ST_WB*ADDR_W +: ADDR_W] + ADDR_W'(1);
    return r;
  endfunction

  assign resume_o = pick(valid_i, addr_i, pc_i);
endmodule

// File: rtl/pipe_irq_ctrl.sv
module pipe_irq_ctrl
  import pic_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] HANDLER_BASE = 16'h0200
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  stall_i,
  input  logic                  irq_i,
  input  logic                  rfi_i,
  output logic [ADDR_W-1:0]     fetch_addr_o,
  output logic [PIC_STAGES-1:0] stage_valid_o,
  output logic                  retire_o,
  output logic [ADDR_W-1:0]     retire_addr_o,
  output logic                  in_handler_o,
  output logic [ADDR_W-1:0]     saved_addr_o
);
  // named events
  logic take_w;
  logic ret_w;
  logic redirect_w;
  logic advance_w;

  logic                         in_handler_q;
  logic [ADDR_W-1:0]            saved_q;
  logic [ADDR_W-1:0]            pc_w;
  logic [ADDR_W-1:0]            resume_w;
  logic [PIC_STAGES-1:0]        valid_w;
  logic [PIC_STAGES*ADDR_W-1:0] addr_w;
  pic_fsel_e                    fsel_w;

  assign ret_w      = rfi_i & in_handler_q;
  assign take_w     = irq_i & ~in_handler_q;
  assign redirect_w = take_w | ret_w;
  assign advance_w  = ~stall_i & ~redirect_w;

  always_comb begin
    if (take_w)         fsel_w = FSEL_HANDLER;
    else if (ret_w)     fsel_w = FSEL_RESUME;
    else if (advance_w) fsel_w = FSEL_SEQ;
    else                fsel_w = FSEL_HOLD;
  end

  pic_fetch_pc #(.ADDR_W(ADDR_W), .HANDLER_BASE(HANDLER_BASE)) u_pc (
    .clk         (clk),
    .rst         (rst),
    .sel         (fsel_w),
    .resume_addr (saved_q),
    .pc_o        (pc_w)
  );

  pic_stage_chain #(.ADDR_W(ADDR_W)) u_chain (
    .clk     (clk),
    .rst     (rst),
    .advance (advance_w),
    .squash  (redirect_w),
    .in_addr (pc_w),
    .valid_o (valid_w),
    .addr_o  (addr_w)
  );

  pic_resume_pick #(.ADDR_W(ADDR_W)) u_pick (
    .valid_i  (valid_w),
    .addr_i   (addr_w),
    .pc_i     (pc_w),
    .resume_o (resume_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      in_handler_q <= 1'b0;
      saved_q      <= '0;
    end else if (take_w) begin
      in_handler_q <= 1'b1;
      saved_q      <= resume_w;
    end else if (ret_w) begin
      in_handler_q <= 1'b0;
    end
  end

  assign fetch_addr_o  = pc_w;
  assign stage_valid_o = valid_w;
  assign retire_o      = valid_w[ST_WB] & (~stall_i | redirect_w);
  assign retire_addr_o = addr_w[ST_WB*ADDR_W +: ADDR_W];
  assign in_handler_o  = in_handler_q;
  assign saved_addr_o  = saved_q;
endmodule

// File: rtl/pipe_irq_ctrl_chk.sv
module pipe_irq_ctrl_chk #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] HANDLER_BASE = 16'h0200
) (
  input logic              clk,
  input logic              rst,
  input logic              stall_i,
  input logic              irq_i,
  input logic              rfi_i,
  input logic [ADDR_W-1:0] fetch_addr_o,
  input logic [4:0]        stage_valid_o,
  input logic              retire_o,
  input logic              in_handler_o,
  input logic [ADDR_W-1:0] saved_addr_o
);
  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (stage_valid_o == '0) && !in_handler_o && (fetch_addr_o == '0));

  assert_seq_R2: assert property (@(posedge clk) disable iff (rst)
    (!stall_i && !irq_i && !rfi_i) |=>
      (fetch_addr_o == ADDR_W'($past(fetch_addr_o) + 1)) && stage_valid_o[0]);

  assert_retire_valid_R3: assert property (@(posedge clk) disable iff (rst)
    retire_o |-> stage_valid_o[4]);

  assert_stall_R4: assert property (@(posedge clk) disable iff (rst)
    (stall_i && !(irq_i && !in_handler_o) && !(rfi_i && in_handler_o)) |=>
      $stable(fetch_addr_o) && $stable(stage_valid_o));

  assert_take_R5: assert property (@(posedge clk) disable iff (rst)
    (irq_i && !in_handler_o) |=>
      in_handler_o && (fetch_addr_o == HANDLER_BASE) && (stage_valid_o == '0));

  assert_saved_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !(irq_i && !in_handler_o) |=> $stable(saved_addr_o));

  assert_mask_R7: assert property (@(posedge clk) disable iff (rst)
    (in_handler_o && !rfi_i) |=> in_handler_o);

  assert_return_R8: assert property (@(posedge clk) disable iff (rst)
    (rfi_i && in_handler_o) |=>
      !in_handler_o && (fetch_addr_o == $past(saved_addr_o)) && (stage_valid_o == '0));

  assert_stall_take_R9: assert property (@(posedge clk) disable iff (rst)
    (stall_i && irq_i && !in_handler_o && stage_valid_o[4]) |-> retire_o);

  assert_both_R11: assert property (@(posedge clk) disable iff (rst)
    (irq_i && rfi_i && in_handler_o) |=> !in_handler_o);
endmodule

bind pipe_irq_ctrl pipe_irq_ctrl_chk #(.ADDR_W(ADDR_W), .HANDLER_BASE(HANDLER_BASE)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .stall_i       (stall_i),
  .irq_i         (irq_i),
  .rfi_i         (rfi_i),
  .fetch_addr_o  (fetch_addr_o),
  .stage_valid_o (stage_valid_o),
  .retire_o      (retire_o),
  .in_handler_o  (in_handler_o),
  .saved_addr_o  (saved_addr_o)
);

// File: tb/pipe_irq_ctrl_tb.sv
module pipe_irq_ctrl_tb;
  localparam int AW = 16;
  localparam logic [AW-1:0] HB = 16'h0200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stall_i = 1'b0;
  logic irq_i = 1'b0;
  logic rfi_i = 1'b0;
  logic [AW-1:0] fetch_addr_o;
  logic [4:0]    stage_valid_o;
  logic          retire_o;
  logic [AW-1:0] retire_addr_o;
  logic          in_handler_o;
  logic [AW-1:0] saved_addr_o;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk; // 50 MHz

  pipe_irq_ctrl #(.ADDR_W(AW), .HANDLER_BASE(HB)) u_dut (
    .clk(clk), .rst(rst), .stall_i(stall_i), .irq_i(irq_i), .rfi_i(rfi_i),
    .fetch_addr_o(fetch_addr_o), .stage_valid_o(stage_valid_o),
    .retire_o(retire_o), .retire_addr_o(retire_addr_o),
    .in_handler_o(in_handler_o), .saved_addr_o(saved_addr_o)
  );

  // reference model, stage index 0 is fetch, 4 is write-back
  logic          m_v [5];
  logic [AW-1:0] m_a [5];
  logic [AW-1:0] m_pc;
  logic          m_h;
  logic [AW-1:0] m_sv;
  logic [AW-1:0] exp_q [$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 5; i++) begin m_v[i] = 1'b0; m_a[i] = '0; end
    m_pc = '0; m_h = 1'b0; m_sv = '0;
  endtask

  function automatic logic [4:0] m_valid_vec();
    logic [4:0] r;
    for (int i = 0; i < 5; i++) r[i] = m_v[i];
    return r;
  endfunction

  task automatic compare_state(input string tag);
    chk(fetch_addr_o == m_pc, tag, "fetch_addr", fetch_addr_o, m_pc);
    chk(stage_valid_o == m_valid_vec(), tag, "stage_valid",
        AW'(stage_valid_o), AW'(m_valid_vec()));
    chk(in_handler_o == m_h, tag, "in_handler", AW'(in_handler_o), AW'(m_h));
    chk(saved_addr_o == m_sv, tag, "saved_addr", saved_addr_o, m_sv);
  endtask

  // one cycle: drive at negedge, score retire, model the edge, compare state
  task automatic step(input bit irq, input bit rfi, input bit stall, input string tag);
    bit take, ret, exp_ret;
    logic [AW-1:0] r;
    irq_i = irq; rfi_i = rfi; stall_i = stall;
    #1;
    take = irq && !m_h;
    ret  = rfi && m_h;
    exp_ret = m_v[4] && (!stall || take || ret);
    if (exp_ret) exp_q.push_back(m_a[4]);
    // monitor: pop and compare against what the design retires
    if (retire_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10", "unexpected retire", retire_addr_o, '0);
      end else begin
        r = exp_q.pop_front();
        chk(retire_addr_o == r, "R3", "retire_addr", retire_addr_o, r);
      end
    end else begin
      chk(!exp_ret, "R3", "missing retire", '0, exp_ret ? m_a[4] : '0);
      if (exp_ret) void'(exp_q.pop_front());
    end
    @(posedge clk);
    if (take || ret) begin
      if (take) begin
        r = m_pc;
        for (int i = 0; i < 4; i++) if (m_v[i]) r = m_a[i];
        if (m_v[4]) r = m_a[4] + AW'(1);
        m_sv = r;
        m_pc = HB;
      end else begin
        m_pc = m_sv;
      end
      m_h = take;
      for (int i = 0; i < 5; i++) m_v[i] = 1'b0;
    end else if (!stall) begin
      for (int i = 4; i > 0; i--) begin m_v[i] = m_v[i-1]; m_a[i] = m_a[i-1]; end
      m_v[0] = 1'b1; m_a[0] = m_pc;
      m_pc = m_pc + AW'(1);
    end
    @(negedge clk);
    compare_state(tag);
  endtask

  task automatic do_reset();
    rst = 1'b1; irq_i = 0; rfi_i = 0; stall_i = 0;
    repeat (2) @(negedge clk);
    model_reset();
    compare_state("R1");
    rst = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    model_reset();
    @(negedge clk);
    do_reset();
    // R2, R3: fill and stream
    for (int k = 0; k < 8; k++) step(0, 0, 0, "R2");
    chk(fetch_addr_o == 16'd8, "R2", "fetch after 8", fetch_addr_o, 16'd8);
    // R4: stall holds
    for (int k = 0; k < 3; k++) step(0, 0, 1, "R4");
    // R5, R6: interrupt with write-back valid
    step(1, 0, 0, "R5");
    chk(saved_addr_o == 16'd4, "R6", "resume wb+1", saved_addr_o, 16'd4);
    chk(fetch_addr_o == HB, "R5", "handler fetch", fetch_addr_o, HB);
    // R7: requests masked in handler
    for (int k = 0; k < 6; k++) step(1, 0, 0, "R7");
    step(0, 0, 1, "R7");
    // R8: return
    step(0, 1, 0, "R8");
    chk(fetch_addr_o == 16'd4, "R8", "resume fetch", fetch_addr_o, 16'd4);
    for (int k = 0; k < 7; k++) step(0, 0, 0, "R8");
    // R9: stall and interrupt together
    step(1, 0, 1, "R9");
    for (int k = 0; k < 3; k++) step(0, 0, 0, "R9");
    // R11: return and interrupt together
    step(1, 1, 0, "R11");
    chk(!in_handler_o, "R11", "return wins", AW'(in_handler_o), '0);
    for (int k = 0; k < 3; k++) step(0, 0, 0, "R11");
    step(1, 0, 0, "R11");
    chk(in_handler_o, "R11", "irq later taken", AW'(in_handler_o), 16'd1);
    step(0, 1, 0, "R8");
    // R8: rfi outside handler ignored
    for (int k = 0; k < 2; k++) step(0, 1, 0, "R8");
    // R6: write-back empty, oldest squashed wins
    do_reset();
    step(0, 0, 0, "R6"); step(0, 0, 0, "R6");
    step(1, 0, 0, "R6");
    chk(saved_addr_o == 16'd0, "R6", "oldest squashed", saved_addr_o, 16'd0);
    step(0, 1, 0, "R6");
    for (int k = 0; k < 6; k++) step(0, 0, 0, "R10");
    // R6: all empty, current fetch address
    do_reset();
    step(1, 0, 0, "R6");
    chk(saved_addr_o == 16'd0, "R6", "empty pipe", saved_addr_o, 16'd0);
    step(0, 1, 1, "R8");
    for (int k = 0; k < 7; k++) step(0, 0, 0, "R10");
    chk(exp_q.size() == 0, "R10", "scoreboard drained", AW'(exp_q.size()), '0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule